// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns data bytes into an asynchronous serial frame on a single output line. Software, or a neighbouring controller, supplies a 30-bit line-setup word. The same word drives a matching receiver. It sets the bit period in clock cycles, the word length (5 to 8 bits), one or two stop bits, and the parity treatment. Parity can be absent, odd, even, forced low or forced high.

A byte is handed over by raising the write strobe while the busy flag is low. The setup word is sampled in that same cycle and held for the whole frame, so the supplier may change it at any time without corrupting a frame in flight. A break request forces the line low for as long as it is held, abandoning any frame in progress. On release, the line is held high for one bit period before the transmitter accepts data again.

Top module: `uart_serializer`

## Requirements
- R1: After synchronous reset the line is high and busy is low.
- R2: A byte is accepted on a rising clock edge where the write strobe is high and busy is low. From the next clock the line carries the low start bit and busy is high.
- R3: Every bit of a frame lasts exactly D clocks, where D is setup bits [23:0], and D = 0 is treated as 1.
- R4: Data bits follow the start bit least significant first. Setup bits [29:28] = 0, 1, 2, 3 select 8, 7, 6, 5 data bits.
- R5: Setup bit 26 enables a parity bit after the data. With bit 25 = 0, bit 24 = 0 gives odd parity and bit 24 = 1 gives even parity. With bit 25 = 1, the parity bit is the value of bit 24 (0 space, 1 mark).
- R6: Setup bit 27 = 1 sends two high stop bits; 0 sends one.
- R7: A write strobe while busy is high has no effect: no extra frame is sent and the frame in progress is unchanged.
- R8: The setup word is captured when a byte is accepted. Changes during a frame do not alter that frame, and the next frame uses the new value.
- R9: While the break request is high, busy is high and, from the next clock on, the line is low. This holds even if a frame was in progress, which is then abandoned.
- R10: After the break request falls, the line is high for D clocks with busy high (D from the setup word present at release), then the transmitter is idle.
- R11: Busy falls on the clock after the last stop bit ends, so a frame occupies exactly D × (1 + data bits + parity bit + stop bits) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe offering a byte |
| wr_byte | input | 8 | Byte to send |
| brk_req | input | 1 | Hold the line in break while high |
| cfg_word | input | 30 | Line setup: divisor, word length, stop bits, parity |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | High when a new byte cannot be accepted |

## Verification
The hardest situations to reach from the ports are a setup change landing mid-frame and a break landing mid-frame. In both, the interesting event has to arrive while internal state that the ports cannot see is partway through a frame.

The bench gets there from a single frame task. That task counts clocks from the accepting edge and, at a chosen bit index, alters the setup word, pulses the strobe or raises the break. The expected line is rebuilt clock by clock from the setup value captured when the byte was handed over.

// File: rtl/uart_ser_pkg.sv
package uart_ser_pkg;
  localparam int CFG_W = 30;
  localparam int DIV_W = 24;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [1:0]       len_code;
    logic             two_stop;
    logic             par_en;
    logic             par_fixed;
    logic             par_sel;
    logic [DIV_W-1:0] div;
  } ser_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BREAK, ST_RECOVER
  } ser_state_t;

  function automatic logic [3:0] data_bits(input logic [1:0] len_code);
    return 4'd8 - {2'b00, len_code};
  endfunction

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] div);
    return (div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div;
  endfunction

  function automatic logic parity_bit(input ser_cfg_t c, input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] used;
    logic              x;
    used = d & (8'hFF >> c.len_code);
    x    = ^used;
    if (c.par_fixed) return c.par_sel;
    return c.par_sel ? x : ~x;
  endfunction
endpackage

// File: rtl/ser_baud_timer.sv
module ser_baud_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (restart || tick) cnt <= period - 1'b1;
    else                      cnt <= cnt - 1'b1;
  end

  // the count never exceeds the period it was loaded from
  assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (rst)
    !restart |=> (cnt <= $past(period) - 1'b1));
endmodule

// File: rtl/ser_frame_ctrl.sv
module ser_frame_ctrl
  import uart_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              brk_req,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              bit_tick,
  output logic              timer_restart,
  output logic [DIV_W-1:0]  timer_period,
  output logic              tx_line,
  output logic              busy
);
  ser_cfg_t          cfg_in, cfg_q;
  ser_state_t        state;
  logic [BYTE_W-1:0] shreg;
  logic [3:0]        bits_left;
  logic              stops_left;
  logic              par_q;
  logic              accept;
  logic              brk_release;

  assign cfg_in      = ser_cfg_t'(cfg_word);
  assign busy        = (state != ST_IDLE) || brk_req;
  assign accept      = wr_en && !busy;
  assign brk_release = (state == ST_BREAK) && !brk_req;

  assign timer_restart = accept || brk_release;
  assign timer_period  = timer_restart ? eff_div(cfg_in.div) : eff_div(cfg_q.div);

  always_comb begin
    case (state)
      ST_START: tx_line = 1'b0;
      ST_DATA:  tx_line = shreg[0];
      ST_PAR:   tx_line = par_q;
      ST_BREAK: tx_line = 1'b0;
      default:  tx_line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cfg_q      <= '0;
      shreg      <= '0;
      bits_left  <= '0;
      stops_left <= 1'b0;
      par_q      <= 1'b0;
    end else if (brk_req) begin
      state <= ST_BREAK;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_START;
          shreg     <= wr_byte;
          cfg_q     <= cfg_in;
          par_q     <= parity_bit(cfg_in, wr_byte);
          bits_left <= data_bits(cfg_in.len_code);
        end
        ST_START: if (bit_tick) state <= ST_DATA;
        ST_DATA: if (bit_tick) begin
          shreg     <= shreg >> 1;
          bits_left <= bits_left - 1'b1;
          if (bits_left == 4'd1) begin
            state      <= cfg_q.par_en ? ST_PAR : ST_STOP;
            stops_left <= cfg_q.two_stop;
          end
        end
        ST_PAR: if (bit_tick) begin
          state      <= ST_STOP;
          stops_left <= cfg_q.two_stop;
        end
        ST_STOP: if (bit_tick) begin
          if (stops_left) stops_left <= 1'b0;
          else            state      <= ST_IDLE;
        end
        ST_BREAK: begin
          state <= ST_RECOVER;
          cfg_q <= cfg_in;
        end
        ST_RECOVER: if (bit_tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_line);
  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && !tx_line));
  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!bit_tick && !brk_req && state != ST_IDLE && state != ST_BREAK) |=> $stable(tx_line));
  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy && state != ST_START) |=> (state != ST_START));
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && state != ST_BREAK && !brk_req) |=> $stable(cfg_q));
  assert_break_low_R9: assert property (@(posedge clk) disable iff (rst)
    brk_req |=> (!tx_line && busy));
endmodule

// File: rtl/uart_serializer.sv
module uart_serializer
  import uart_ser_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_byte,
  input  logic        brk_req,
  input  logic [29:0] cfg_word,
  output logic        tx_line,
  output logic        busy
);
  logic             bit_tick;
  logic             timer_restart;
  logic [DIV_W-1:0] timer_period;

  ser_baud_timer #(.CNT_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (timer_restart),
    .period  (timer_period),
    .tick    (bit_tick)
  );

  ser_frame_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_byte       (wr_byte),
    .brk_req       (brk_req),
    .cfg_word      (cfg_word),
    .bit_tick      (bit_tick),
    .timer_restart (timer_restart),
    .timer_period  (timer_period),
    .tx_line       (tx_line),
    .busy          (busy)
  );
endmodule

// File: tb/uart_serializer_test.sv
module uart_serializer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic        brk_req = 1'b0;
  logic [29:0] cfg_word = '0;
  logic        tx_line, busy;
  int          n_run = 0;
  int          n_fail = 0;

  uart_serializer uut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [29:0] mk_cfg(input int len, input bit two, input bit pen,
                                         input bit pfix, input bit psel, input int div);
    return {len[1:0], two, pen, pfix, psel, div[23:0]};
  endfunction

  // mode: 0 plain, 1 strobe while busy, 2 change setup mid-frame, 3 break mid-frame
  task automatic frame(input logic [29:0] cfg, input logic [7:0] d, input int mode,
                       input string req);
    int   div, nd, nb, errs, ones;
    logic exp_bits[12];
    div = (cfg[23:0] == 0) ? 1 : int'(cfg[23:0]);
    nd  = 8 - int'(cfg[29:28]);
    nb  = 0;
    exp_bits[nb++] = 1'b0;
    ones = 0;
    for (int i = 0; i < nd; i++) begin
      exp_bits[nb++] = d[i];
      ones += d[i];
    end
    if (cfg[26]) exp_bits[nb++] = cfg[25] ? cfg[24] : (cfg[24] ? ones[0] : ~ones[0]);
    exp_bits[nb++] = 1'b1;
    if (cfg[27]) exp_bits[nb++] = 1'b1;
    while (busy) @(negedge clk);
    cfg_word = cfg; wr_byte = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    errs = 0;
    for (int k = 0; k < nb; k++) begin
      for (int c = 0; c < div; c++) begin
        if (mode == 3 && k == 2) begin
          check(!tx_line && busy, "R9 break mid-frame line", tx_line, 0);
          brk_req = 1'b0;
          @(negedge clk);
          for (int r = 0; r < div; r++) begin
            if (tx_line !== 1'b1 || busy !== 1'b1) errs++;
            @(negedge clk);
          end
          check(errs == 0 && !busy && tx_line, "R10 recovery interval", errs, 0);
          return;
        end
        if (tx_line !== exp_bits[k] || busy !== 1'b1) errs++;
        if (k == 1 && c == 0) begin
          if (mode == 1) begin wr_en = 1'b1; wr_byte = ~d; end
          if (mode == 2) cfg_word = mk_cfg(3, 1, 1, 1, 1, 1);
          if (mode == 3 && k == 1 && c == div - 1) brk_req = 1'b1;
        end else begin
          wr_en = 1'b0;
        end
        if (mode == 3 && k == 1 && c == div - 1) brk_req = 1'b1;
        @(negedge clk);
      end
    end
    check(errs == 0, req, errs, 0);
    check(!busy && tx_line, {req, " / R11 busy falls after stop"}, busy, 0);
  endtask

  task automatic t_reset;
    check(tx_line === 1'b1 && busy === 1'b0, "R1 reset state", {tx_line, busy}, 2);
  endtask

  task automatic t_formats;
    frame(mk_cfg(0, 0, 0, 0, 0, 4), 8'hA5, 0, "R2 R4 8N1 frame");
    frame(mk_cfg(1, 0, 1, 0, 1, 3), 8'h6B, 0, "R5 7 bits even parity");
    frame(mk_cfg(3, 0, 1, 0, 0, 5), 8'h13, 0, "R5 5 bits odd parity");
    frame(mk_cfg(2, 0, 1, 1, 1, 2), 8'h00, 0, "R5 6 bits mark parity");
    frame(mk_cfg(0, 1, 1, 1, 0, 3), 8'hFF, 0, "R6 two stops space parity");
    frame(mk_cfg(0, 0, 0, 0, 0, 0), 8'h3C, 0, "R3 divisor zero acts as one");
    frame(mk_cfg(0, 1, 0, 0, 0, 1), 8'hC3, 0, "R3 R6 divisor one two stops");
  endtask

  task automatic t_busy_write;
    frame(mk_cfg(0, 0, 1, 0, 0, 3), 8'h5A, 1, "R7 strobe while busy");
    for (int i = 0; i < 12; i++) begin
      check(tx_line && !busy, "R7 no extra frame", {tx_line, busy}, 2);
      @(negedge clk);
    end
  endtask

  task automatic t_cfg_change;
    frame(mk_cfg(0, 0, 0, 0, 0, 4), 8'h81, 2, "R8 setup change mid-frame");
    frame(mk_cfg(3, 1, 1, 1, 1, 1), 8'h15, 0, "R8 next frame uses new setup");
  endtask

  task automatic t_break_idle;
    brk_req = 1'b1;
    #1 check(busy === 1'b1, "R9 busy with break", busy, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_byte = 8'hEE;
    for (int i = 0; i < 6; i++) begin
      check(!tx_line && busy, "R9 line held low", tx_line, 0);
      @(negedge clk);
    end
    wr_en = 1'b0;
    cfg_word = mk_cfg(0, 0, 0, 0, 0, 3);
    brk_req = 1'b0;
    @(negedge clk);
    for (int r = 0; r < 3; r++) begin
      check(tx_line && busy, "R10 high interval after break", {tx_line, busy}, 3);
      @(negedge clk);
    end
    check(tx_line && !busy, "R10 idle after interval", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_formats();
    t_busy_write();
    t_cfg_change();
    t_break_idle();
    frame(mk_cfg(0, 0, 0, 0, 0, 2), 8'hF0, 3, "R9 break mid-frame");
    frame(mk_cfg(1, 0, 0, 0, 0, 2), 8'h77, 0, "R2 frame after break");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule